// File: doc/BRIEF.md
# Triple-Axis Sample Buffer with Trigger Capture

This block holds up to 32 acceleration samples, each one complete X, Y, Z triple of 16-bit words, between a sensor front end and a register read path. A 2-bit mode input selects one of four policies: bypass (buffer disabled and empty), fill-and-stop (fills to full, then rejects new samples), stream (always keeps the newest 32), and trigger capture. Trigger capture behaves like stream until the selected interrupt line fires. It then cuts the history back to the newest `wm_level` entries and fills once more until it is full.

Samples enter on a valid/ready port. `in_ready` is tied high: the front end is never stalled, and whether a sample is stored, dropped, or stored over the oldest entry is decided by the mode alone. The read side is also valid/ready. `out_valid` is high while the buffer holds data outside bypass. `out_x/y/z` show the oldest triple with no delay, and one handshake removes the whole triple. A reader that takes only part of the triple loses the rest. Status outputs are the entry count, the sticky trigger flag, watermark and overrun. `DEPTH` must be a power of two.

Top module: `triax_fifo`

## Requirements
- R1: `count` is always in the range 0 to 32. Triples leave in the order they arrived, and `out_valid` is high exactly when the mode is not bypass and `count` is nonzero.
- R2: The mode codes are 00 bypass, 01 fill-and-stop, 10 stream and 11 trigger capture.
- R3: While the mode is 00, `count` and `triggered` go to 0 on the next edge. Pushes and pops are ignored, and contents held before bypass are discarded.
- R4: In mode 01 a sample that arrives while `count` is 32 is dropped, unless a pop happens in the same cycle.
- R5: In mode 10 a sample that arrives while full evicts the oldest entry. A push and a pop together while full keep `count` at 32.
- R6: In mode 11, before a trigger, the buffer acts as in R5. On the trigger edge the buffer first applies that cycle's push and pop, then discards the oldest entries until at most `wm_level` remain. After that, samples are stored only if room exists or a pop happens in the same cycle.
- R7: `trig_sel`=0 selects `irq_a` as the trigger and 1 selects `irq_b`. `triggered` rises on the first trigger in mode 11 and stays high until the mode is 00. Later triggers have no effect.
- R8: `watermark` is high when `count` >= `wm_level`, in every mode. A `wm_level` of 0 holds it high.
- R9: `overrun` is high when the mode is not 00 and `count` is 32. A pop that lowers the count clears it.
- R10: `out_x/y/z` show the oldest triple combinationally. A pop removes all three words together.
- R11: `in_ready` is always 1.
- R12: After reset the buffer is empty and `triggered` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | New sample present |
| in_ready | output | 1 | Always 1; no back-pressure |
| in_x | input | 16 | X word of new sample |
| in_y | input | 16 | Y word of new sample |
| in_z | input | 16 | Z word of new sample |
| out_valid | output | 1 | Oldest triple available |
| out_ready | input | 1 | Pop request from read path |
| out_x | output | 16 | X word of oldest triple |
| out_y | output | 16 | Y word of oldest triple |
| out_z | output | 16 | Z word of oldest triple |
| mode | input | 2 | Buffer policy code |
| wm_level | input | 6 | Watermark level and post-trigger keep count |
| trig_sel | input | 1 | Trigger line select |
| irq_a | input | 1 | Trigger candidate line 0 |
| irq_b | input | 1 | Trigger candidate line 1 |
| count | output | 6 | Entries held, 0 to 32 |
| triggered | output | 1 | Trigger has been taken |
| watermark | output | 1 | Count at or above level |
| overrun | output | 1 | Buffer full outside bypass |

## Verification
The assertions watch every cycle. They check the count bound, clearing in bypass, the full count holding in fill and stream modes, the trigger flag staying set, watermark forced high at level zero, and overrun falling after a pop from full. Properties cannot show which data survives an eviction or a trigger trim, or the order in which triples leave. The bench shows these by comparing every word against a queue model: it trims on a trigger, freezes after the trigger, ignores a second trigger and the unselected line, and trims to zero at level zero.

// File: rtl/triax_fifo_pkg.sv
package triax_fifo_pkg;
  parameter int SAMPLE_W = 16;
  parameter int AXES     = 3;

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'b00,
    MODE_FILL   = 2'b01,
    MODE_STREAM = 2'b10,
    MODE_TRIG   = 2'b11
  } fifo_mode_e;
endpackage

// File: rtl/triax_fifo_store.sv
module triax_fifo_store #(
  parameter int DEPTH = 32,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/triax_fifo_trig.sv
module triax_fifo_trig
  import triax_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  fifo_mode_e mode,
  input  logic       trig_sel,
  input  logic       irq_a,
  input  logic       irq_b,
  output logic       fire,
  output logic       taken
);
  logic line;

  assign line = trig_sel ? irq_b : irq_a;
  assign fire = (mode == MODE_TRIG) && !taken && line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   taken <= 1'b0;
    else if (mode == MODE_BYPASS) taken <= 1'b0;
    else if (fire)                taken <= 1'b1;
  end
endmodule

// File: rtl/triax_fifo_ctrl.sv
module triax_fifo_ctrl
  import triax_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fifo_mode_e    mode,
  input  logic          in_valid,
  input  logic          pop_req,
  input  logic          taken,
  input  logic          fire,
  input  logic [CW-1:0] keep_lvl,
  output logic [CW-1:0] cnt,
  output logic [AW-1:0] head,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          rd_valid
);
  logic          full, do_pop, do_push, evict, overwrite;
  logic [CW-1:0] c1, drop, cnt_nx;
  logic [AW-1:0] head_nx;

  always_comb begin
    full      = (cnt == CW'(DEPTH));
    rd_valid  = (mode != MODE_BYPASS) && (cnt != '0);
    do_pop    = rd_valid && pop_req;
    overwrite = (mode == MODE_STREAM) || ((mode == MODE_TRIG) && !taken);
    do_push   = in_valid && (mode != MODE_BYPASS) && (!full || do_pop || overwrite);
    evict     = do_push && full && !do_pop;
    c1        = cnt + CW'(do_push) - CW'(do_pop) - CW'(evict);
    drop      = (fire && (c1 > keep_lvl)) ? (c1 - keep_lvl) : '0;
    cnt_nx    = c1 - drop;
    head_nx   = head + AW'(do_pop | evict) + drop[AW-1:0];
    wr_en     = do_push;
    wr_addr   = head + cnt[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      head <= '0;
    end else if (mode == MODE_BYPASS) begin
      cnt  <= '0;
      head <= '0;
    end else begin
      cnt  <= cnt_nx;
      head <= head_nx;
    end
  end
endmodule

// File: rtl/triax_fifo.sv
module triax_fifo
  import triax_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_x,
  input  logic [SAMPLE_W-1:0] in_y,
  input  logic [SAMPLE_W-1:0] in_z,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_x,
  output logic [SAMPLE_W-1:0] out_y,
  output logic [SAMPLE_W-1:0] out_z,
  input  logic [1:0]          mode,
  input  logic [CW-1:0]       wm_level,
  input  logic                trig_sel,
  input  logic                irq_a,
  input  logic                irq_b,
  output logic [CW-1:0]       count,
  output logic                triggered,
  output logic                watermark,
  output logic                overrun
);
  fifo_mode_e    mode_e;
  logic          fire, wr_en;
  logic [AW-1:0] head, wr_addr;
  logic [SAMPLE_W-1:0] lane_in  [AXES];
  logic [SAMPLE_W-1:0] lane_out [AXES];

  assign mode_e = fifo_mode_e'(mode);
  assign in_ready = 1'b1;

  triax_fifo_trig u_trig (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .trig_sel(trig_sel),
    .irq_a(irq_a), .irq_b(irq_b), .fire(fire), .taken(triggered)
  );

  triax_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .in_valid(in_valid),
    .pop_req(out_ready), .taken(triggered), .fire(fire), .keep_lvl(wm_level),
    .cnt(count), .head(head), .wr_en(wr_en), .wr_addr(wr_addr),
    .rd_valid(out_valid)
  );

  assign lane_in[0] = in_x;
  assign lane_in[1] = in_y;
  assign lane_in[2] = in_z;

  for (genvar a = 0; a < AXES; a++) begin : g_lane
    triax_fifo_store #(.DEPTH(DEPTH), .W(SAMPLE_W)) u_store (
      .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(lane_in[a]),
      .rd_addr(head), .rd_data(lane_out[a])
    );
  end

  assign out_x = lane_out[0];
  assign out_y = lane_out[1];
  assign out_z = lane_out[2];

  assign watermark = (count >= wm_level);
  assign overrun   = (mode_e != MODE_BYPASS) && (count == CW'(DEPTH));
endmodule

// File: rtl/triax_fifo_chk.sv
module triax_fifo_chk #(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_ready,
  input logic [1:0]    mode,
  input logic [CW-1:0] wm_level,
  input logic [CW-1:0] count,
  input logic          triggered,
  input logic          watermark,
  input logic          overrun
);
  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R3
  bypass_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> (count == '0) && !triggered);

  // R4
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && count == CW'(DEPTH) && !out_ready) |=> (count == CW'(DEPTH)));

  // R5
  stream_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && count == CW'(DEPTH) && in_valid) |=> (count == CW'(DEPTH)));

  // R7
  trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (triggered && mode != 2'b00) |=> triggered);

  // R8
  wm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wm_level == '0) |-> watermark);

  // R9
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && count == CW'(DEPTH) && out_ready && !in_valid) |=> !overrun);
endmodule

bind triax_fifo triax_fifo_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/triax_fifo_bench.sv
module triax_fifo_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b0;
  logic [15:0] in_x = '0, in_y = '0, in_z = '0;
  logic        in_ready, out_valid;
  logic [15:0] out_x, out_y, out_z;
  logic [1:0]  mode = 2'b00;
  logic [5:0]  wm_level = '0;
  logic        trig_sel = 1'b0, irq_a = 1'b0, irq_b = 1'b0;
  logic [5:0]  count;
  logic        triggered, watermark, overrun;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  logic [47:0] q[$];
  bit mtrig = 0;

  always #5 clk = ~clk;

  triax_fifo u_triax_fifo (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    int  sz = q.size();
    bit  ev = (mode != 2'b00) && (sz > 0);
    chk(count == 6'(sz), tag, "R1 count", count, sz);
    chk(out_valid == ev, tag, "R1 out_valid", out_valid, ev);
    chk(triggered == mtrig, tag, "R7 triggered", triggered, mtrig);
    chk(watermark == (sz >= int'(wm_level)), tag, "R8 watermark", watermark, sz >= int'(wm_level));
    chk(overrun == ((mode != 2'b00) && sz == 32), tag, "R9 overrun", overrun, (mode != 2'b00) && sz == 32);
    chk(in_ready == 1'b1, tag, "R11 in_ready", in_ready, 1);
    if (ev) chk({out_x, out_y, out_z} == q[0], tag, "R10 data", {out_x, out_y, out_z}, q[0]);
  endtask

  task automatic model_step();
    int sz0 = q.size();
    bit popd = 0;
    logic [47:0] d = {in_x, in_y, in_z};
    if (mode == 2'b00) begin
      q.delete();
      mtrig = 0;
    end else begin
      if (out_ready && sz0 > 0) begin void'(q.pop_front()); popd = 1; end
      if (in_valid) begin
        if (sz0 < 32 || popd) q.push_back(d);
        else if (mode == 2'b10 || (mode == 2'b11 && !mtrig)) begin
          void'(q.pop_front());
          q.push_back(d);
        end
      end
      if (mode == 2'b11 && !mtrig && (trig_sel ? irq_b : irq_a)) begin
        while (q.size() > int'(wm_level)) void'(q.pop_front());
        mtrig = 1;
      end
    end
  endtask

  task automatic cyc(input bit v, input bit p, input logic [1:0] m, input logic [5:0] s,
                     input bit ts, input bit ia, input bit ib, input string tag);
    in_valid = v; out_ready = p; mode = m; wm_level = s;
    trig_sel = ts; irq_a = ia; irq_b = ib;
    in_x = 16'($urandom); in_y = 16'($urandom); in_z = 16'($urandom);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R12");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R12");

    // R2 R4: fill-and-stop past full, then push+pop at full, then drain
    for (int i = 0; i < 40; i++) cyc(1, 0, 2'b01, 6'd8, 0, 0, 0, "R4");
    cyc(1, 1, 2'b01, 6'd8, 0, 0, 0, "R4");
    cyc(0, 0, 2'b01, 6'd8, 0, 0, 0, "R4");
    for (int i = 0; i < 10; i++) cyc(0, 1, 2'b01, 6'd8, 0, 0, 0, "R9");
    for (int i = 0; i < 10; i++) cyc(0, 1, 2'b01, 6'd20, 0, 0, 0, "R8");

    // R3: bypass ignores traffic and empties
    for (int i = 0; i < 3; i++) cyc(1, 1, 2'b00, 6'd5, 0, 0, 0, "R3");
    cyc(0, 0, 2'b00, 6'd0, 0, 0, 0, "R8");

    // R5: stream overwrite and push+pop at full
    for (int i = 0; i < 45; i++) cyc(1, 0, 2'b10, 6'd16, 0, 0, 0, "R5");
    for (int i = 0; i < 10; i++) cyc(1, 1, 2'b10, 6'd16, 0, 0, 0, "R5");
    for (int i = 0; i < 5; i++)  cyc(0, 1, 2'b10, 6'd16, 0, 0, 0, "R10");

    // R6: trigger on irq_a keeps 5, refills, freezes; R7 repeat ignored
    cyc(0, 0, 2'b00, 6'd5, 0, 0, 0, "R3");
    for (int i = 0; i < 12; i++) cyc(1, 0, 2'b11, 6'd5, 0, 0, 0, "R6");
    cyc(1, 0, 2'b11, 6'd5, 0, 1, 0, "R6");
    for (int i = 0; i < 30; i++) cyc(1, 0, 2'b11, 6'd5, 0, 0, 0, "R6");
    cyc(1, 0, 2'b11, 6'd5, 0, 1, 1, "R7");
    for (int i = 0; i < 3; i++) cyc(1, 1, 2'b11, 6'd5, 0, 0, 0, "R6");

    // R7: re-arm via bypass, select irq_b, level 0 trims everything
    cyc(0, 0, 2'b00, 6'd0, 1, 0, 0, "R7");
    for (int i = 0; i < 6; i++) cyc(1, 0, 2'b11, 6'd0, 1, 0, 0, "R7");
    for (int i = 0; i < 2; i++) cyc(1, 0, 2'b11, 6'd0, 1, 1, 0, "R7");
    cyc(1, 0, 2'b11, 6'd0, 1, 0, 1, "R7");
    for (int i = 0; i < 4; i++) cyc(1, 0, 2'b11, 6'd0, 1, 0, 0, "R6");

    // R1 R11: random mix
    begin
      logic [1:0] m = 2'b01;
      logic [5:0] s = 6'd10;
      for (int i = 0; i < 3000; i++) begin
        if ($urandom_range(0, 63) == 0) m = 2'($urandom);
        if ($urandom_range(0, 31) == 0) s = 6'($urandom_range(0, 33));
        cyc(1'($urandom), ($urandom_range(0, 3) == 0), m, s, 1'($urandom),
            ($urandom_range(0, 40) == 0), ($urandom_range(0, 40) == 0), "R1");
      end
    end
    finish_run();
  end
endmodule